// File: doc/BRIEF.md
# Indexed Byte Read-Modify-Write Sequencer with Register Copy

This block carries out one byte-wide read-modify-write on memory at an indexed address. A caller presents a 16-bit base value, a signed 8-bit offset, an 8-bit operation code and the current flag byte, then pulses `start`. The sequencer does the following in order:

- forms the address;
- reads the byte over a synchronous memory port whose read data arrives one cycle after the request;
- passes the byte through a small operation unit (rotates and shifts, single-bit clear, single-bit set, single-bit test);
- writes the byte back.

For most codes it also writes the modified byte into a register-file entry chosen by the low three bits of the operation code. That register write happens in the same cycle as the memory write.

Bit-test codes only produce flags. They write neither memory nor a register. The flag byte computed by the operation unit is held and shown together with the one-cycle `done` pulse. Prefix decoding and the register file itself sit outside this block.

Top module: `idx_rmw_seq`

## Requirements
- R1: The memory address for both the read and the write is the base value plus the sign-extended offset, modulo 2^16. For example, base 0x0005 with offset 0xF0 gives 0xFFF5, and base 0xFFFF with offset 0x01 gives 0x0000.
- R2: Cycle timing, counted from the rising edge that samples `start`:
  - `busy` is high in cycles 1 to 5.
  - The read request (`mem_en`=1, `mem_we`=0) is issued in cycle 2.
  - Cycles 1 and 3 issue no memory request.
  - The write slot is cycle 4.
  - `busy` is low in cycle 6.
- R3: `start` is ignored while `busy` is high. No new operation begins and the running one is not disturbed.
- R4: When opcode[7:6]=00, opcode[5:3] selects the operation on byte d. The carry-in is flag bit 0.
  - 0: rotate left; bit 7 goes to bit 0 and to carry.
  - 1: rotate right; bit 0 goes to bit 7 and to carry.
  - 2: rotate left through carry.
  - 3: rotate right through carry.
  - 4: shift left with 0 fill.
  - 5: shift right keeping bit 7.
  - 6: shift left with 1 fill.
  - 7: shift right with 0 fill.
  - For 4 and 6, bit 7 goes to carry. For 5 and 7, bit 0 goes to carry.
- R5: When opcode[7:6]=10, bit opcode[5:3] of the byte is cleared. When opcode[7:6]=11, that bit is set. In both cases the output flag byte equals the input flag byte.
- R6: For every code with opcode[7:6] other than 01, the modified byte is written back to memory in cycle 4. If opcode[2:0] is not 6, the same modified byte (not the byte read) is also written in cycle 4 to register code opcode[2:0] on `rf_sel`. The codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A, and 4 and 5 are the plain H and L entries.
- R7: When opcode[2:0]=6, the write-back still happens but there is no register write.
- R8: When opcode[7:6]=01 (bit test), there is neither a memory write nor a register write for any value of opcode[2:0], and memory keeps its old byte.
- R9: Flag bit positions are S=7, Z=6, H=4, P/V=2, N=1, C=0. Bits 5 and 3 pass through from the input flags.
  - Rotate/shift: S is result bit 7, Z is set when the result is zero, H=0, P/V=1 on even parity, N=0, and C is the bit shifted out.
  - Bit test of bit b: Z and P/V are the inverse of the tested bit, H=1, N=0, S=1 only when b=7 and the bit is 1, and C is kept.
- R10: `done` is high for exactly one cycle (cycle 5), and `flags_out` shows the operation's flags in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base_val | input | 16 | Index base value |
| offset | input | 8 | Signed displacement |
| opcode | input | 8 | Operation code |
| flags_in | input | 8 | Current flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 8 | Resulting flag byte |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read request |
| rf_we | output | 1 | Register-file write enable |
| rf_sel | output | 3 | Register-file destination code |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The assertions check the following on every cycle:
- `done` never lasts two cycles.
- `busy` cannot drop before `done`.
- Every memory write reuses the address of the read two cycles earlier.
- A register write only ever goes with a memory write and never targets code 6.

Only the bench's scenarios can show the rest: the data results of all 256 codes, the flag values, the signed address wrap, the absence of any write for bit tests whatever the low code, and that a `start` pulse arriving mid-operation leaves both the sequence and memory unchanged.

// File: rtl/idx_rmw_pkg.sv
package idx_rmw_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_READ  = 3'd2,
        S_MOD   = 3'd3,
        S_WRITE = 3'd4,
        S_DONE  = 3'd5
    } st_e;

    localparam int F_C  = 0;
    localparam int F_N  = 1;
    localparam int F_PV = 2;
    localparam int F_H  = 4;
    localparam int F_Z  = 6;
    localparam int F_S  = 7;

    localparam logic [1:0] G_SHIFT = 2'b00;
    localparam logic [1:0] G_TEST  = 2'b01;
    localparam logic [1:0] G_CLR   = 2'b10;
    localparam logic [1:0] G_SET   = 2'b11;

    localparam logic [2:0] NO_COPY = 3'd6;
endpackage

// File: rtl/idx_rmw_agen.sv
module idx_rmw_agen #(
    parameter int AW    = 16,
    parameter int DSP_W = 8
) (
    input  logic [AW-1:0]    base_i,
    input  logic [DSP_W-1:0] disp_i,
    output logic [AW-1:0]    ea_o
);
    localparam int EXT_W = AW - DSP_W;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DSP_W-1]}}, disp_i};
        ea_o     = base_i + disp_ext;
    end
endmodule

// File: rtl/idx_rmw_alu.sv
module idx_rmw_alu
    import idx_rmw_pkg::*;
(
    input  logic [DW-1:0] op_i,
    input  logic [DW-1:0] din_i,
    input  logic [DW-1:0] fin_i,
    output logic [DW-1:0] dout_o,
    output logic [DW-1:0] fout_o,
    output logic          wr_mem_o,
    output logic          copy_o
);
    logic [1:0]    grp;
    logic [2:0]    sel;
    logic          cin;
    logic          cout;
    logic [DW-1:0] mask;

    always_comb begin
        grp    = op_i[7:6];
        sel    = op_i[5:3];
        cin    = fin_i[F_C];
        cout   = 1'b0;
        mask   = DW'(1) << sel;
        dout_o = din_i;
        fout_o = fin_i;
        unique case (grp)
            G_SHIFT: begin
                unique case (sel)
                    3'd0: begin cout = din_i[7]; dout_o = {din_i[6:0], din_i[7]}; end
                    3'd1: begin cout = din_i[0]; dout_o = {din_i[0], din_i[7:1]}; end
                    3'd2: begin cout = din_i[7]; dout_o = {din_i[6:0], cin}; end
                    3'd3: begin cout = din_i[0]; dout_o = {cin, din_i[7:1]}; end
                    3'd4: begin cout = din_i[7]; dout_o = {din_i[6:0], 1'b0}; end
                    3'd5: begin cout = din_i[0]; dout_o = {din_i[7], din_i[7:1]}; end
                    3'd6: begin cout = din_i[7]; dout_o = {din_i[6:0], 1'b1}; end
                    default: begin cout = din_i[0]; dout_o = {1'b0, din_i[7:1]}; end
                endcase
                fout_o[F_S]  = dout_o[7];
                fout_o[F_Z]  = (dout_o == '0);
                fout_o[F_H]  = 1'b0;
                fout_o[F_PV] = ~^dout_o;
                fout_o[F_N]  = 1'b0;
                fout_o[F_C]  = cout;
            end
            G_TEST: begin
                fout_o[F_Z]  = ~|(din_i & mask);
                fout_o[F_PV] = ~|(din_i & mask);
                fout_o[F_H]  = 1'b1;
                fout_o[F_N]  = 1'b0;
                fout_o[F_S]  = (sel == 3'd7) && din_i[7];
            end
            G_CLR:   dout_o = din_i & ~mask;
            default: dout_o = din_i | mask;
        endcase
        wr_mem_o = (grp != G_TEST);
        copy_o   = (grp != G_TEST) && (op_i[2:0] != NO_COPY);
    end
endmodule

// File: rtl/idx_rmw_seq.sv
module idx_rmw_seq
    import idx_rmw_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DSP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_val,
    input  logic [DSP_W-1:0] offset,
    input  logic [DW-1:0]    opcode,
    input  logic [DW-1:0]    flags_in,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    flags_out,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             rf_we,
    output logic [2:0]       rf_sel,
    output logic [DW-1:0]    rf_wdata
);
    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    base;
        logic [DSP_W-1:0] disp;
        logic [AW-1:0]    ea;
        logic [DW-1:0]    op;
        logic [DW-1:0]    fin;
        logic [DW-1:0]    res;
        logic [DW-1:0]    flg;
    } regs_t;

    regs_t         r_q, r_d;
    logic [AW-1:0] ea_calc;
    logic [DW-1:0] alu_dout, alu_fout;
    logic          alu_wr, alu_copy;

    idx_rmw_agen #(.AW(AW), .DSP_W(DSP_W)) u_agen (
        .base_i (r_q.base),
        .disp_i (r_q.disp),
        .ea_o   (ea_calc)
    );

    idx_rmw_alu u_alu (
        .op_i     (r_q.op),
        .din_i    (mem_rdata),
        .fin_i    (r_q.fin),
        .dout_o   (alu_dout),
        .fout_o   (alu_fout),
        .wr_mem_o (alu_wr),
        .copy_o   (alu_copy)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: if (start) begin
                r_d.st   = S_ADDR;
                r_d.base = base_val;
                r_d.disp = offset;
                r_d.op   = opcode;
                r_d.fin  = flags_in;
            end
            S_ADDR: begin
                r_d.ea = ea_calc;
                r_d.st = S_READ;
            end
            S_READ: r_d.st = S_MOD;
            S_MOD: begin
                r_d.res = alu_dout;
                r_d.flg = alu_fout;
                r_d.st  = S_WRITE;
            end
            S_WRITE: r_d.st = S_DONE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        busy      = (r_q.st != S_IDLE);
        done      = (r_q.st == S_DONE);
        flags_out = r_q.flg;
        mem_addr  = r_q.ea;
        mem_wdata = r_q.res;
        mem_we    = (r_q.st == S_WRITE) && alu_wr;
        mem_en    = (r_q.st == S_READ) || mem_we;
        rf_we     = (r_q.st == S_WRITE) && alu_copy;
        rf_sel    = r_q.op[2:0];
        rf_wdata  = r_q.res;
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_write_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_en, 2) && !$past(mem_we, 2) && mem_addr == $past(mem_addr, 2)));
    p_copy_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_we);
    p_no_copy_code6_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_sel != NO_COPY));
    p_done_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_en, 3) && !$past(mem_we, 3)));
endmodule

// File: tb/idx_rmw_seq_tb.sv
module idx_rmw_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_val = '0;
    logic [7:0]  offset = '0;
    logic [7:0]  opcode = '0;
    logic [7:0]  flags_in = '0;
    logic        busy, done, mem_en, mem_we, rf_we;
    logic [7:0]  flags_out, mem_wdata, rf_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic [2:0]  rf_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    byte unsigned mem [int];

    always #2.5 clk = ~clk;

    idx_rmw_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_val(base_val),
        .offset(offset), .opcode(opcode), .flags_in(flags_in),
        .busy(busy), .done(done), .flags_out(flags_out),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata)
    );

    function automatic int mem_peek(input int a);
        if (mem.exists(a)) return mem[a];
        return ((a & 255) ^ (a >> 8) ^ 'h5A) & 255;
    endfunction

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[int'(mem_addr)] = mem_wdata;
        else if (mem_en) mem_rdata <= 8'(mem_peek(int'(mem_addr)));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void ref_op(input int op, input int d, input int f,
                                   output int r, output int fo, output bit wr, output bit cp);
        int grp = op >> 6;
        int sel = (op >> 3) & 7;
        int c = f & 1;
        int co = 0;
        int ones = 0;
        r = d;
        fo = f;
        if (grp == 0) begin
            case (sel)
                0: begin co = d >> 7; r = ((d << 1) | co) & 255; end
                1: begin co = d & 1;  r = (d >> 1) | (co << 7); end
                2: begin co = d >> 7; r = ((d << 1) | c) & 255; end
                3: begin co = d & 1;  r = (d >> 1) | (c << 7); end
                4: begin co = d >> 7; r = (d * 2) & 255; end
                5: begin co = d & 1;  r = (d >> 1) | (d & 128); end
                6: begin co = d >> 7; r = (d * 2 + 1) & 255; end
                default: begin co = d & 1; r = d >> 1; end
            endcase
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            fo = (f & 'h28) | (r & 128) | ((r == 0) ? 64 : 0) | ((ones % 2 == 0) ? 4 : 0) | co;
        end else if (grp == 1) begin
            int bv = (d >> sel) & 1;
            fo = (f & 'h29) | 16 | (bv ? 0 : 'h44) | ((sel == 7 && bv == 1) ? 128 : 0);
        end else if (grp == 2) begin
            r = d & ~(1 << sel) & 255;
        end else begin
            r = d | (1 << sel);
        end
        wr = (grp != 1);
        cp = wr && ((op & 7) != 6);
    endfunction

    task automatic run_op(input int base, input int disp, input int op, input int f, input bit poke);
        int sd = (disp >= 128) ? disp - 256 : disp;
        int ea = (base + sd) & 'hFFFF;
        int d = mem_peek(ea);
        int r, fo;
        bit wr, cp;
        ref_op(op, d, f, r, fo, wr, cp);
        @(negedge clk);
        start = 1; base_val = 16'(base); offset = 8'(disp); opcode = 8'(op); flags_in = 8'(f);
        @(negedge clk);
        start = poke;
        if (poke) begin opcode = 8'(op ^ 'h40); base_val = 16'(base + 3); end
        chk(busy && !done && !mem_en, "R2 cycle1", {busy, done, mem_en}, 3'b100);
        @(negedge clk);
        start = 0;
        chk(mem_en && !mem_we && !rf_we, "R2 read slot", {mem_en, mem_we, rf_we}, 3'b100);
        chk(int'(mem_addr) == ea, "R1 read address", mem_addr, ea);
        @(negedge clk);
        chk(busy && !mem_en && !rf_we && !done, "R2 cycle3", {busy, mem_en, rf_we}, 3'b100);
        @(negedge clk);
        chk(mem_we == wr && mem_en == wr, wr ? "R6 write-back" : "R8 no write", mem_we, wr);
        if (wr) begin
            chk(int'(mem_addr) == ea, "R1 write address", mem_addr, ea);
            chk(int'(mem_wdata) == r, (op >> 6) == 0 ? "R4 result" : "R5 result", mem_wdata, r);
        end
        chk(rf_we == cp, cp ? "R6 copy" : ((op >> 6) == 1 ? "R8 no copy" : "R7 no copy"), rf_we, cp);
        if (cp) begin
            chk(int'(rf_sel) == (op & 7), "R6 copy target", rf_sel, op & 7);
            chk(int'(rf_wdata) == r, "R6 copy value", rf_wdata, r);
        end
        @(negedge clk);
        chk(done && busy, "R10 done", {done, busy}, 2'b11);
        chk(int'(flags_out) == fo, (op >> 6) == 2 || (op >> 6) == 3 ? "R5 flags" : "R9 flags", flags_out, fo);
        @(negedge clk);
        chk(!done && !busy, poke ? "R3 ignored start" : "R10 done width", {done, busy}, 0);
        chk(mem_peek(ea) == (wr ? r : d), wr ? "R6 memory" : "R8 memory kept", mem_peek(ea), wr ? r : d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !mem_en && !rf_we, "R2 reset state", {busy, done, mem_en, rf_we}, 0);
        run_op('h0005, 'hF0, 'h00, 'h00, 0);   // R1 negative wrap, R4 rotate left, copy to code 0
        run_op('hFFFF, 'h01, 'h1B, 'h01, 0);   // R1 positive wrap, R4 rotate right via carry
        run_op('h4000, 'h10, 'h36, 'h00, 0);   // R7 shift-in-one to memory only
        run_op('h4000, 'h7F, 'h2F, 'h28, 0);   // R4 arithmetic right, R9 pass-through bits
        run_op('h1234, 'h80, 'hA4, 'hFF, 0);   // R5 clear bit 4, copy to H
        run_op('h1234, 'h81, 'hED, 'h00, 0);   // R5 set bit 5, copy to L
        run_op('h2000, 'h00, 'h7B, 'h00, 0);   // R8 bit test, code 3
        run_op('h2000, 'h00, 'h7E, 'h01, 0);   // R8 bit test, code 6
        run_op('h3000, 'h05, 'h3F, 'h00, 1);   // R3 start while busy
        mem['h5555] = 0;
        run_op('h5555, 'h00, 'h38, 'h00, 0);   // R9 zero result
        for (int op = 0; op < 256; op++)
            run_op((op * 397) & 'hFFFF, (op * 37) & 255, op, (op * 13) & 255, 0);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule